// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block takes the four level-sensitive PCI interrupt lines of a bridge and steers each of them onto one of sixteen ISA interrupt request lines. The choice for each line is a 4-bit steering code held in three bridge configuration bytes, written through a byte-wide configuration port. A code of zero detaches its line. Several PCI lines may share one ISA request, in which case that request is the OR of all the lines steered to it.

The two interrupt inputs from the disk controller are fixed on the two highest ISA requests. Any PCI line steered there is merged with them by OR. Three codes name ISA requests that are reserved for system use. Steering any line to one of them raises a routing-error flag, but the line still drives the request it names. All outputs are registered. The block feeds the downstream interrupt controllers, which are not part of it.

Top module: `pirq_router`

## Requirements
- R1: While reset is high, and in the first cycle after it, every ISA output and the error flag are 0. After reset all steering codes are 0, so no PCI line drives any output.
- R2: The steering codes sit in fixed fields. Line 0 uses bits [7:4] of byte 0x55. Line 1 uses bits [3:0] of byte 0x56. Line 2 uses bits [7:4] of byte 0x56. Line 3 uses bits [7:4] of byte 0x57. A nonzero code n steers the line to ISA output n.
- R3: A steering code of 0 disconnects the line. ISA output 0 is never driven by any PCI line.
- R4: Each ISA output is the OR of every PCI line whose steering code selects it.
- R5: Disk interrupt input 0 drives ISA output 14 and input 1 drives ISA output 15. Each is ORed with any PCI line steered to that output.
- R6: The error flag is high whenever at least one line carries code 2, 8 or 13. That line still drives the named output.
- R7: An ISA output reflects the PCI and disk input levels sampled at the previous rising clock edge. A configuration byte written at one edge takes effect in the outputs registered at the next edge.
- R8: Configuration writes to any offset other than 0x55 to 0x57 have no effect. The low nibbles of bytes 0x55 and 0x57 have no effect. Nothing changes when the write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte data |
| pci_irq | input | 4 | PCI interrupt levels, lines 0 to 3 |
| ide_irq | input | 2 | Disk controller interrupt levels |
| isa_irq | output | 16 | Registered ISA interrupt request levels |
| route_err | output | 1 | Registered flag: a line is steered to a reserved request |

## Verification
The disk inputs and a PCI line steered to output 14 or 15 can drive the same request in the same cycle. For every steering code, the bench places each PCI line in turn on that code while it drives all four disk-input combinations together with all sixteen PCI patterns. Every output is compared with an OR of the contributors that the bench computes itself, so a dropped or overriding source shows up as a single mismatched bit. The same sweep also lands reserved codes beside shared ones, so the error flag and the merged levels are judged together.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;
  // steering nibble width and derived output count
  localparam int STEER_W    = 4;
  localparam int ISA_LINES  = 1 << STEER_W;
  localparam int PCI_LINES  = 4;
  // configuration byte offsets holding the steering fields
  localparam logic [7:0] OFS_LINE0  = 8'h55;
  localparam logic [7:0] OFS_LINE12 = 8'h56;
  localparam logic [7:0] OFS_LINE3  = 8'h57;
  // reserved ISA requests: 2, 8, 13
  localparam logic [ISA_LINES-1:0] RSV_DEFAULT = 16'h2104;

  typedef logic [STEER_W-1:0] steer_t;
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_route_pkg::*;
#(
  parameter int NUM_PCI = PCI_LINES
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [7:0]                      addr,
  input  logic [7:0]                      wdata,
  output logic [NUM_PCI-1:0][STEER_W-1:0] steer
);
  logic [NUM_PCI-1:0][STEER_W-1:0] steer_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      steer_q <= '0;
    end else if (we) begin
      unique case (addr)
        OFS_LINE0:  steer_q[0] <= wdata[7:4];
        OFS_LINE12: begin
          steer_q[1] <= wdata[3:0];
          steer_q[2] <= wdata[7:4];
        end
        OFS_LINE3:  steer_q[3] <= wdata[7:4];
        default: ;
      endcase
    end
  end

  assign steer = steer_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(we)) |-> $stable(steer)) else $error("cfg changed without write"); // R8
endmodule

// File: rtl/pirq_decode.sv
module pirq_decode
  import pirq_route_pkg::*;
#(
  parameter int                   NUM_PCI  = PCI_LINES,
  parameter int                   NUM_ISA  = ISA_LINES,
  parameter logic [NUM_ISA-1:0]   RSV_MASK = RSV_DEFAULT
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_PCI-1:0][STEER_W-1:0] steer,
  output logic [NUM_PCI-1:0][NUM_ISA-1:0] sel_oh,
  output logic                            rsv_hit
);
  always_comb begin
    sel_oh  = '0;
    rsv_hit = 1'b0;
    for (int i = 0; i < NUM_PCI; i++) begin
      if (steer[i] != '0) begin
        sel_oh[i][steer[i]] = 1'b1;
        if (RSV_MASK[steer[i]]) rsv_hit = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_PCI; g++) begin : g_chk
    AST_DIS_NO_SEL: assert property (@(posedge clk) disable iff (rst)
      (steer[g] == '0) |-> (sel_oh[g] == '0)) else $error("disabled line selects"); // R3
  end
endmodule

// File: rtl/pirq_merge.sv
module pirq_merge #(
  parameter int NUM_PCI = 4,
  parameter int NUM_ISA = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_PCI-1:0][NUM_ISA-1:0] sel_oh,
  input  logic [NUM_PCI-1:0]              pci_lvl,
  input  logic [1:0]                      ide_lvl,
  input  logic                            rsv_hit,
  output logic [NUM_ISA-1:0]              isa_q,
  output logic                            err_q
);
  localparam int IDE_BASE = NUM_ISA - 2;

  logic [NUM_ISA-1:0] isa_d;

  always_comb begin
    isa_d = '0;
    for (int j = 0; j < NUM_ISA; j++) begin
      for (int i = 0; i < NUM_PCI; i++) begin
        isa_d[j] = isa_d[j] | (sel_oh[i][j] & pci_lvl[i]);
      end
    end
    isa_d[IDE_BASE]   = isa_d[IDE_BASE]   | ide_lvl[0];
    isa_d[IDE_BASE+1] = isa_d[IDE_BASE+1] | ide_lvl[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isa_q <= '0;
      err_q <= 1'b0;
    end else begin
      isa_q <= isa_d;
      err_q <= rsv_hit;
    end
  end

  AST_IDE0_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ide_lvl[0])) |-> isa_q[IDE_BASE]) else $error("ide0 lost"); // R5
  AST_IDE1_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ide_lvl[1])) |-> isa_q[IDE_BASE+1]) else $error("ide1 lost"); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(pci_lvl) == '0 && $past(ide_lvl) == '0) |-> (isa_q == '0)) else $error("spurious irq"); // R4
  AST_IRQ0_QUIET: assert property (@(posedge clk) disable iff (rst)
    !isa_q[0]) else $error("irq0 driven"); // R3
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_route_pkg::*;
#(
  parameter int                 NUM_PCI  = PCI_LINES,
  parameter int                 NUM_ISA  = ISA_LINES,
  parameter logic [NUM_ISA-1:0] RSV_MASK = RSV_DEFAULT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_addr,
  input  logic [7:0]         cfg_wdata,
  input  logic [NUM_PCI-1:0] pci_irq,
  input  logic [1:0]         ide_irq,
  output logic [NUM_ISA-1:0] isa_irq,
  output logic               route_err
);
  logic [NUM_PCI-1:0][STEER_W-1:0] steer;
  logic [NUM_PCI-1:0][NUM_ISA-1:0] sel_oh;
  logic                            rsv_hit;

  pirq_cfg_regs #(.NUM_PCI(NUM_PCI)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .steer(steer)
  );

  pirq_decode #(.NUM_PCI(NUM_PCI), .NUM_ISA(NUM_ISA), .RSV_MASK(RSV_MASK)) u_dec (
    .clk(clk), .rst(rst), .steer(steer), .sel_oh(sel_oh), .rsv_hit(rsv_hit)
  );

  pirq_merge #(.NUM_PCI(NUM_PCI), .NUM_ISA(NUM_ISA)) u_mrg (
    .clk(clk), .rst(rst), .sel_oh(sel_oh), .pci_lvl(pci_irq), .ide_lvl(ide_irq),
    .rsv_hit(rsv_hit), .isa_q(isa_irq), .err_q(route_err)
  );

  for (genvar g = 0; g < NUM_PCI; g++) begin : g_rsv
    AST_RSV_FLAG: assert property (@(posedge clk) disable iff (rst)
      (steer[g] != '0 && RSV_MASK[steer[g]]) |=> route_err) else $error("reserved not flagged"); // R6
  end
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (isa_irq == '0 && !route_err)) else $error("not clear after reset"); // R1
endmodule

// File: tb/pirq_router_test.sv
module pirq_router_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [3:0]  pci_irq = '0;
  logic [1:0]  ide_irq = '0;
  logic [15:0] isa_irq;
  logic        route_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int m_steer [4];

  always #2.5 clk = ~clk;

  pirq_router uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pci_irq(pci_irq), .ide_irq(ide_irq), .isa_irq(isa_irq), .route_err(route_err)
  );

  function automatic logic [15:0] exp_isa(input logic [3:0] p, input logic [1:0] d);
    logic [15:0] e = '0;
    for (int i = 0; i < 4; i++)
      if (m_steer[i] != 0 && p[i]) e[m_steer[i]] = 1'b1;
    e[14] = e[14] | d[0];
    e[15] = e[15] | d[1];
    return e;
  endfunction

  function automatic logic exp_err();
    logic e = 1'b0;
    for (int i = 0; i < 4; i++)
      if (m_steer[i] == 2 || m_steer[i] == 8 || m_steer[i] == 13) e = 1'b1;
    return e;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2 field positions modelled here; other offsets and low nibbles ignored (R8)
  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      8'h55: m_steer[0] = int'(d[7:4]);
      8'h56: begin m_steer[1] = int'(d[3:0]); m_steer[2] = int'(d[7:4]); end
      8'h57: m_steer[3] = int'(d[7:4]);
      default: ;
    endcase
  endtask

  task automatic set_route(input int a, input int b, input int c, input int d);
    cfg_write(8'h55, {4'(a), 4'h0});
    cfg_write(8'h56, {4'(c), 4'(b)});
    cfg_write(8'h57, {4'(d), 4'h0});
  endtask

  task automatic apply_check(input logic [3:0] p, input logic [1:0] d, input string tag);
    pci_irq = p; ide_irq = d;
    @(posedge clk); @(negedge clk);
    chk(tag, isa_irq, exp_isa(p, d));
    chk("R6 err", {15'd0, route_err}, {15'd0, exp_err()});
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_steer[i] = 0;
    pci_irq = 4'hF; ide_irq = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 in reset isa", isa_irq, 16'h0);
    chk("R1 in reset err", {15'd0, route_err}, 16'h0);
    rst = 1'b0;
    pci_irq = 4'h0; ide_irq = 2'b00;
    @(posedge clk); @(negedge clk);
    chk("R1 first cycle after reset", isa_irq, 16'h0);
    apply_check(4'hF, 2'b00, "R1 routing disabled after reset");

    // R7: latency of one edge
    set_route(5, 0, 0, 0);
    apply_check(4'h0, 2'b00, "R7 idle");
    pci_irq = 4'h1;
    #1;
    chk("R7 before edge", isa_irq, 16'h0);
    @(negedge clk);
    chk("R7 after edge", isa_irq, 16'h0020);

    // R8: ignored offsets, low nibbles, no strobe
    set_route(0, 0, 0, 0);
    cfg_write(8'h55, 8'h0F);
    cfg_write(8'h57, 8'h0F);
    cfg_write(8'h54, 8'hFF);
    cfg_write(8'h58, 8'hFF);
    cfg_we = 1'b0; cfg_addr = 8'h56; cfg_wdata = 8'hFF;
    @(posedge clk); @(negedge clk);
    apply_check(4'hF, 2'b00, "R8 ignored writes");

    // R4: all lines shared on one output, and on the disk outputs (R5)
    set_route(11, 11, 11, 11);
    for (int p = 0; p < 16; p++) apply_check(4'(p), 2'b00, "R4 shared");
    set_route(14, 15, 14, 15);
    for (int p = 0; p < 16; p++)
      for (int d = 0; d < 4; d++) apply_check(4'(p), 2'(d), "R5 merge");

    // R2 R3 R6: each line swept over every code, others at fixed codes
    for (int ln = 0; ln < 4; ln++) begin
      for (int v = 0; v < 16; v++) begin
        int r [4];
        r[0] = 3; r[1] = 9; r[2] = 10; r[3] = 14;
        r[ln] = v;
        set_route(r[0], r[1], r[2], r[3]);
        for (int p = 0; p < 16; p++)
          for (int d = 0; d < 4; d++)
            apply_check(4'(p), 2'(d), (v == 0) ? "R3 disabled" : "R2 steer");
      end
    end

    // R6: reserved codes on several lines at once
    set_route(2, 8, 13, 0);
    apply_check(4'hF, 2'b00, "R6 reserved still drives");
    set_route(1, 4, 6, 7);
    apply_check(4'hF, 2'b00, "R6 cleared");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule